// File: doc/BRIEF.md
# Flash Reset and Quad Enable Sequencer

This block brings a serial NOR flash into a known state after power-up or whenever a start request arrives. It drives a command phase engine one command at a time: it presents an opcode together with its line width, its direction and an optional data byte, and holds them until the engine reports the command complete. Between commands it inserts fixed waits whose lengths are cycle-count parameters, so the same block serves any clock rate.

The sequence depends on two selections that are captured when the run begins. Vendor type B starts with a quad-exit command. Both vendor types then get the software reset pair. If quad operation is requested, vendor type A gets write enable followed by a status write that sets the quad-enable bit, and each status write is followed by a status read. The write and read repeat until the bit reads back as set, up to a retry limit. Vendor type B instead receives one opcode that switches it into four-line command mode. `ready` rises once the flash is in the requested mode. `err` rises if the retry limit is used up.

Top module: `flash_init_seq`

## Requirements
- R1: While reset is held, `ready`, `err` and `cmd_valid` are low. With `AUTO_START` = 1 the sequence starts by itself after reset with no `start` pulse, and `ready` stays low and `cmd_valid` never overlaps `ready` until the run completes.
- R2: For vendor type B (`vendor_sel` = 1) the first command is opcode 0xF5 with `cmd_four_line` = 1. Vendor type A (`vendor_sel` = 0) never receives it. No other command sets `cmd_four_line`.
- R3: The reset pair is opcode 0x66 then opcode 0x99, both one-line with no data. After 0xF5 and after 0x66 the next command appears between `WAIT_SHORT` and `WAIT_SHORT`+2 cycles after the completing `cmd_done`; after 0x99 the wait is `WAIT_LONG` cycles, with the same bounds.
- R4: `quad_req` and `vendor_sel` are captured at the start of a run; changing them during the run does not change the command list.
- R5: For vendor type A with quad requested, 0x99 is followed by write enable 0x06 (no data), then status write 0x01 with `cmd_has_data` = 1, `cmd_read` = 0 and `cmd_wdata` = 0x40, then status read 0x05 with `cmd_has_data` = 1 and `cmd_read` = 1, all one-line.
- R6: The status read result is tested on bit 6 (mask 0x40) of `cmd_rdata`, ignoring all other bits. While it is clear, the status write and read pair repeats with no new write enable; once it is set, `ready` rises.
- R7: If bit 6 is still clear after `MAX_TRIES` status reads, the block stops issuing commands, raises `err` and leaves `ready` low. A new run clears `err`.
- R8: For vendor type B with quad requested, 0x99 is followed by a single one-line opcode 0x35, after which `ready` rises.
- R9: With quad not requested, `ready` rises after the wait that follows 0x99 and no quad-enable command is issued, for either vendor.
- R10: A `start` pulse during a run is ignored; a `start` pulse after completion or failure begins a new run and drops `ready`.
- R11: While `cmd_valid` is high and `cmd_done` is low, `cmd_valid` stays high and the opcode, line width, direction and data byte stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| quad_req | input | 1 | 1 requests four-line operation at the end of the run |
| vendor_sel | input | 1 | 0 selects vendor type A, 1 selects vendor type B |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_opcode | output | 8 | Instruction byte |
| cmd_four_line | output | 1 | Instruction sent on four lines |
| cmd_read | output | 1 | Data phase reads from the flash |
| cmd_has_data | output | 1 | Command has a one-byte data phase |
| cmd_wdata | output | 8 | Byte written in the data phase |
| cmd_done | input | 1 | Engine finished the presented command (one-cycle pulse) |
| cmd_rdata | input | 8 | Byte read in the data phase, valid with `cmd_done` |
| ready | output | 1 | Flash is in the requested mode |
| err | output | 1 | Quad-enable verification exhausted its retries |

## Verification
The assertions assume the engine raises `cmd_done` only while `cmd_valid` is high, for a single cycle, and with `cmd_rdata` valid in that same cycle; the bench responder waits for a presented command, holds it for a fixed latency and then pulses `cmd_done` once, so it never completes a command that was not offered. They also assume `start` is a pulse, which the bench drives for exactly one cycle. Selection inputs are changed mid-run only to probe R4, never in the cycle a run is started.

// File: rtl/flash_init_pkg.sv
package flash_init_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_QEXIT,
      ST_WAIT_QX,
      ST_RSTEN,
      ST_WAIT_RE,
      ST_RST,
      ST_WAIT_RS,
      ST_WREN,
      ST_WRSR,
      ST_RDSR,
      ST_QPI,
      ST_DONE,
      ST_FAIL
   } seq_state_t;

   typedef struct packed {
      logic       valid;
      logic [7:0] opcode;
      logic       four_line;
      logic       rd;
      logic       has_data;
      logic [7:0] wdata;
   } cmd_t;

   localparam logic [7:0] OPC_QUAD_EXIT  = 8'hF5;
   localparam logic [7:0] OPC_RST_ENABLE = 8'h66;
   localparam logic [7:0] OPC_RST        = 8'h99;
   localparam logic [7:0] OPC_WR_ENABLE  = 8'h06;
   localparam logic [7:0] OPC_STAT_WR    = 8'h01;
   localparam logic [7:0] OPC_STAT_RD    = 8'h05;
   localparam logic [7:0] OPC_QPI_ENTER  = 8'h35;

   function automatic logic is_wait(input seq_state_t s);
      return (s == ST_WAIT_QX) || (s == ST_WAIT_RE) || (s == ST_WAIT_RS);
   endfunction

   function automatic logic is_rest(input seq_state_t s);
      return (s == ST_IDLE) || (s == ST_DONE) || (s == ST_FAIL);
   endfunction

endpackage

// File: rtl/flash_init_timer.sv
module flash_init_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == limit - 1'b1);

   // R3: a wait never counts past its own length
   a_r3_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < limit));

endmodule

// File: rtl/flash_init_retry.sv
module flash_init_retry #(
   parameter int MAX_TRIES = 8,
   localparam int RET_W = $clog2(MAX_TRIES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_limit
);

   logic [RET_W-1:0] fails_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fails_q <= '0;
      else if (clr) fails_q <= '0;
      else if (inc) fails_q <= fails_q + 1'b1;
   end

   assign at_limit = (fails_q == RET_W'(MAX_TRIES - 1));

   // R7: the failure count stays below the retry limit
   a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fails_q < RET_W'(MAX_TRIES));

   a_r7_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !at_limit);

endmodule

// File: rtl/flash_init_cmdgen.sv
module flash_init_cmdgen
   import flash_init_pkg::*;
#(
   parameter int QE_BIT = 6
) (
   input  seq_state_t state,
   output cmd_t       cmd
);

   localparam logic [7:0] QE_MASK = 8'(1 << QE_BIT);

   always_comb begin
      cmd = '0;
      unique case (state)
         ST_QEXIT: begin
            cmd.valid     = 1'b1;
            cmd.opcode    = OPC_QUAD_EXIT;
            cmd.four_line = 1'b1;
         end
         ST_RSTEN: begin
            cmd.valid  = 1'b1;
            cmd.opcode = OPC_RST_ENABLE;
         end
         ST_RST: begin
            cmd.valid  = 1'b1;
            cmd.opcode = OPC_RST;
         end
         ST_WREN: begin
            cmd.valid  = 1'b1;
            cmd.opcode = OPC_WR_ENABLE;
         end
         ST_WRSR: begin
            cmd.valid    = 1'b1;
            cmd.opcode   = OPC_STAT_WR;
            cmd.has_data = 1'b1;
            cmd.wdata    = QE_MASK;
         end
         ST_RDSR: begin
            cmd.valid    = 1'b1;
            cmd.opcode   = OPC_STAT_RD;
            cmd.has_data = 1'b1;
            cmd.rd       = 1'b1;
         end
         ST_QPI: begin
            cmd.valid  = 1'b1;
            cmd.opcode = OPC_QPI_ENTER;
         end
         default: cmd = '0;
      endcase
   end

endmodule

// File: rtl/flash_init_fsm.sv
module flash_init_fsm
   import flash_init_pkg::*;
#(
   parameter int QE_BIT = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       quad_req,
   input  logic       vendor_sel,
   input  logic       cmd_done,
   input  logic [7:0] cmd_rdata,
   input  logic       wait_done,
   input  logic       retry_last,
   output seq_state_t state,
   output logic       retry_clr,
   output logic       retry_inc,
   output logic       ready,
   output logic       err
);

   seq_state_t state_q, state_d;
   logic       quad_q, vend_q;
   logic       accept;

   assign accept = go && is_rest(state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         quad_q  <= 1'b0;
         vend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            quad_q <= quad_req;
            vend_q <= vendor_sel;
         end
      end
   end

   always_comb begin
      state_d   = state_q;
      retry_inc = 1'b0;
      unique case (state_q)
         ST_IDLE, ST_DONE, ST_FAIL:
            if (go) state_d = vendor_sel ? ST_QEXIT : ST_RSTEN;
         ST_QEXIT:   if (cmd_done)  state_d = ST_WAIT_QX;
         ST_WAIT_QX: if (wait_done) state_d = ST_RSTEN;
         ST_RSTEN:   if (cmd_done)  state_d = ST_WAIT_RE;
         ST_WAIT_RE: if (wait_done) state_d = ST_RST;
         ST_RST:     if (cmd_done)  state_d = ST_WAIT_RS;
         ST_WAIT_RS:
            if (wait_done) begin
               if (!quad_q)     state_d = ST_DONE;
               else if (vend_q) state_d = ST_QPI;
               else             state_d = ST_WREN;
            end
         ST_WREN:    if (cmd_done) state_d = ST_WRSR;
         ST_WRSR:    if (cmd_done) state_d = ST_RDSR;
         ST_RDSR:
            if (cmd_done) begin
               if (cmd_rdata[QE_BIT]) state_d = ST_DONE;
               else if (retry_last)   state_d = ST_FAIL;
               else begin
                  state_d   = ST_WRSR;
                  retry_inc = 1'b1;
               end
            end
         ST_QPI:     if (cmd_done) state_d = ST_DONE;
         default:    state_d = ST_IDLE;
      endcase
   end

   assign state     = state_q;
   assign retry_clr = accept;
   assign ready     = (state_q == ST_DONE);
   assign err       = (state_q == ST_FAIL);

   // R4: captured selections hold for the whole run
   a_r4_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_rest(state_q) && !$past(accept)) |-> ($stable(quad_q) && $stable(vend_q)));

   // R6: ready after a quad-enable loop only follows a read with the bit set
   a_r6_ready_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready) && $past(state_q) == ST_RDSR) |-> $past(cmd_rdata[QE_BIT]));

   // R7: failure only comes out of a status read
   a_r7_fail_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($past(state_q) == ST_RDSR));

endmodule

// File: rtl/flash_init_seq.sv
module flash_init_seq
   import flash_init_pkg::*;
#(
   parameter int WAIT_SHORT = 100_000,
   parameter int WAIT_LONG  = 1_000_000,
   parameter int MAX_TRIES  = 8,
   parameter int QE_BIT     = 6,
   parameter bit AUTO_START = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       quad_req,
   input  logic       vendor_sel,
   output logic       cmd_valid,
   output logic [7:0] cmd_opcode,
   output logic       cmd_four_line,
   output logic       cmd_read,
   output logic       cmd_has_data,
   output logic [7:0] cmd_wdata,
   input  logic       cmd_done,
   input  logic [7:0] cmd_rdata,
   output logic       ready,
   output logic       err
);

   localparam int WAIT_MAX = (WAIT_LONG > WAIT_SHORT) ? WAIT_LONG : WAIT_SHORT;
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);
   localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(WAIT_SHORT);
   localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(WAIT_LONG);

   if (WAIT_SHORT < 1 || WAIT_LONG < 1) begin : g_bad_wait
      $error("flash_init_seq: wait lengths must be at least one cycle");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("flash_init_seq: MAX_TRIES must be at least one");
   end
   if (QE_BIT < 0 || QE_BIT > 7) begin : g_bad_bit
      $error("flash_init_seq: QE_BIT must select a bit of a byte");
   end

   logic       go;
   seq_state_t state;
   cmd_t       cmd;
   logic       wait_done, retry_clr, retry_inc, retry_last;
   logic [CNT_W-1:0] wait_lim;

   if (AUTO_START) begin : g_boot
      logic boot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) boot_q <= 1'b1;
         else        boot_q <= 1'b0;
      end
      assign go = start || boot_q;
   end else begin : g_manual
      assign go = start;
   end

   flash_init_fsm #(.QE_BIT(QE_BIT)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .quad_req   (quad_req),
      .vendor_sel (vendor_sel),
      .cmd_done   (cmd_done),
      .cmd_rdata  (cmd_rdata),
      .wait_done  (wait_done),
      .retry_last (retry_last),
      .state      (state),
      .retry_clr  (retry_clr),
      .retry_inc  (retry_inc),
      .ready      (ready),
      .err        (err)
   );

   assign wait_lim = (state == ST_WAIT_RS) ? LIM_LONG : LIM_SHORT;

   flash_init_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (is_wait(state)),
      .limit   (wait_lim),
      .expired (wait_done)
   );

   flash_init_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (retry_clr),
      .inc      (retry_inc),
      .at_limit (retry_last)
   );

   flash_init_cmdgen #(.QE_BIT(QE_BIT)) u_cmdgen (
      .state (state),
      .cmd   (cmd)
   );

   assign cmd_valid     = cmd.valid;
   assign cmd_opcode    = cmd.opcode;
   assign cmd_four_line = cmd.four_line;
   assign cmd_read      = cmd.rd;
   assign cmd_has_data  = cmd.has_data;
   assign cmd_wdata     = cmd.wdata;

   // R11: a presented command is held until the engine completes it
   a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_opcode) &&
         $stable(cmd_four_line) && $stable(cmd_read) && $stable(cmd_wdata)));

   // R1: no command is offered while ready or err is shown
   a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ready || err) |-> !cmd_valid);

   // R2: four-line instruction only for the quad-exit opcode
   a_r2_four_line_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_four_line) |-> (cmd_opcode == OPC_QUAD_EXIT));

   // R10: ready drops on the cycle after an accepted start
   a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && start) |=> !ready);

endmodule

// File: tb/flash_init_seq_bench.sv
module flash_init_seq_bench;

   localparam int WS = 5;
   localparam int WL = 12;
   localparam int MT = 3;
   localparam int LAT = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       quad_req = 1'b0;
   logic       vendor_sel = 1'b0;
   logic       cmd_valid, cmd_four_line, cmd_read, cmd_has_data;
   logic [7:0] cmd_opcode, cmd_wdata;
   logic       cmd_done = 1'b0;
   logic [7:0] cmd_rdata = 8'h00;
   logic       ready, err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [7:0] log_op [0:31];
   logic       log_fl [0:31];
   logic       log_rd [0:31];
   logic       log_hd [0:31];
   logic [7:0] log_wd [0:31];
   int         log_cyc [0:31];
   int         done_cyc [0:31];
   int         n_log = 0;
   int         fail_reads = 0;
   int         rd_seen = 0;

   logic [7:0] exp_op [0:31];
   int         exp_n = 0;

   flash_init_seq #(
      .WAIT_SHORT(WS), .WAIT_LONG(WL), .MAX_TRIES(MT), .QE_BIT(6), .AUTO_START(1'b1)
   ) u_flash_init_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .quad_req(quad_req),
      .vendor_sel(vendor_sel), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
      .cmd_four_line(cmd_four_line), .cmd_read(cmd_read), .cmd_has_data(cmd_has_data),
      .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
      .ready(ready), .err(err)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // engine model: log each presented command, complete it after LAT cycles
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cmd_valid && n_log < 32) begin
            log_op[n_log]  = cmd_opcode;
            log_fl[n_log]  = cmd_four_line;
            log_rd[n_log]  = cmd_read;
            log_hd[n_log]  = cmd_has_data;
            log_wd[n_log]  = cmd_wdata;
            log_cyc[n_log] = cyc;
            repeat (LAT) @(negedge clk);
            if (log_op[n_log] == 8'h05) begin
               cmd_rdata = (rd_seen < fail_reads) ? 8'hBF : 8'h42;
               rd_seen++;
            end else begin
               cmd_rdata = 8'h00;
            end
            done_cyc[n_log] = cyc;
            n_log++;
            cmd_done = 1'b1;
            @(negedge clk);
            cmd_done = 1'b0;
         end
      end
   end

   task automatic chk(input string tag, input logic ok, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   task automatic clear_exp();
      exp_n = 0;
   endtask

   task automatic add_exp(input logic [7:0] op);
      exp_op[exp_n] = op;
      exp_n++;
   endtask

   task automatic begin_run(input logic q, input logic v, input int fails);
      n_log = 0;
      rd_seen = 0;
      fail_reads = fails;
      @(negedge clk);
      quad_req = q;
      vendor_sel = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (ready || err) break;
      end
   endtask

   // compare the logged command list with the expected one, and the waits
   task automatic check_seq(input string tag);
      chk({tag, " command count"}, n_log == exp_n, n_log, exp_n);
      for (int i = 0; i < exp_n && i < n_log; i++) begin
         chk({tag, " opcode"}, log_op[i] == exp_op[i], log_op[i], exp_op[i]);
         // R2: only 0xF5 uses four lines
         chk({tag, " R2 line width"}, log_fl[i] == (exp_op[i] == 8'hF5),
             log_fl[i], exp_op[i] == 8'hF5);
         // R5: data phases of the status write and read
         chk({tag, " R5 data phase"},
             log_hd[i] == (exp_op[i] == 8'h01 || exp_op[i] == 8'h05),
             log_hd[i], exp_op[i] == 8'h01 || exp_op[i] == 8'h05);
         chk({tag, " R5 direction"}, log_rd[i] == (exp_op[i] == 8'h05),
             log_rd[i], exp_op[i] == 8'h05);
         if (exp_op[i] == 8'h01)
            chk({tag, " R5 status byte"}, log_wd[i] == 8'h40, log_wd[i], 8'h40);
         if (i > 0) begin
            int w;
            int gap;
            w = (exp_op[i-1] == 8'h99) ? WL :
                (exp_op[i-1] == 8'hF5 || exp_op[i-1] == 8'h66) ? WS : 0;
            gap = log_cyc[i] - done_cyc[i-1];
            if (w > 0)
               chk({tag, " R3 wait length"}, gap >= w && gap <= w + 2, gap, w);
         end
      end
   endtask

   task automatic t_reset_auto();
      @(negedge clk);
      // R1: reset state
      chk("R1 ready in reset", ready == 1'b0, ready, 0);
      chk("R1 err in reset", err == 1'b0, err, 0);
      chk("R1 cmd_valid in reset", cmd_valid == 1'b0, cmd_valid, 0);
      n_log = 0;
      quad_req = 1'b0;
      vendor_sel = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready low while running", ready == 1'b0, ready, 0);
      wait_end();
      clear_exp();
      add_exp(8'h66); add_exp(8'h99);
      // R1 auto start, R9 no quad commands for vendor A
      check_seq("R1 R9 auto start vendor A");
      chk("R9 ready after reset pair", ready == 1'b1, ready, 1);
   endtask

   task automatic t_vendor_b_plain();
      begin_run(1'b0, 1'b1, 0);
      chk("R10 ready drops on restart", ready == 1'b0, ready, 0);
      wait_end();
      clear_exp();
      add_exp(8'hF5); add_exp(8'h66); add_exp(8'h99);
      check_seq("R2 R9 vendor B no quad");
      chk("R9 ready vendor B", ready == 1'b1, ready, 1);
   endtask

   task automatic t_a_quad_first();
      begin_run(1'b1, 1'b0, 0);
      wait_end();
      clear_exp();
      add_exp(8'h66); add_exp(8'h99); add_exp(8'h06); add_exp(8'h01); add_exp(8'h05);
      check_seq("R5 vendor A quad");
      chk("R6 ready after bit seen", ready == 1'b1, ready, 1);
      chk("R6 no err", err == 1'b0, err, 0);
   endtask

   task automatic t_a_quad_retry();
      begin_run(1'b1, 1'b0, 2);
      repeat (4) @(negedge clk);
      // R4: flip selections mid-run
      quad_req = 1'b0;
      vendor_sel = 1'b1;
      wait_end();
      clear_exp();
      add_exp(8'h66); add_exp(8'h99); add_exp(8'h06);
      add_exp(8'h01); add_exp(8'h05); add_exp(8'h01); add_exp(8'h05);
      add_exp(8'h01); add_exp(8'h05);
      check_seq("R4 R6 retry with flipped inputs");
      chk("R6 ready after retries", ready == 1'b1, ready, 1);
   endtask

   task automatic t_a_quad_exhaust();
      begin_run(1'b1, 1'b0, 99);
      wait_end();
      clear_exp();
      add_exp(8'h66); add_exp(8'h99); add_exp(8'h06);
      for (int k = 0; k < MT; k++) begin
         add_exp(8'h01); add_exp(8'h05);
      end
      check_seq("R7 retries exhausted");
      chk("R7 err raised", err == 1'b1, err, 1);
      chk("R7 ready low on fail", ready == 1'b0, ready, 0);
      repeat (10) @(negedge clk);
      chk("R7 no commands after fail", n_log == exp_n && cmd_valid == 1'b0, n_log, exp_n);
      begin_run(1'b0, 1'b0, 0);
      chk("R7 err cleared by new run", err == 1'b0, err, 0);
      wait_end();
      chk("R10 restart after fail completes", ready == 1'b1, ready, 1);
   endtask

   task automatic t_b_quad();
      begin_run(1'b1, 1'b1, 0);
      wait_end();
      clear_exp();
      add_exp(8'hF5); add_exp(8'h66); add_exp(8'h99); add_exp(8'h35);
      check_seq("R8 vendor B quad");
      chk("R8 ready after mode entry", ready == 1'b1, ready, 1);
   endtask

   task automatic t_start_busy();
      begin_run(1'b0, 1'b1, 0);
      repeat (3) @(negedge clk);
      quad_req = 1'b1;
      vendor_sel = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_end();
      clear_exp();
      add_exp(8'hF5); add_exp(8'h66); add_exp(8'h99);
      check_seq("R10 start while busy ignored");
      chk("R10 ready after ignored start", ready == 1'b1, ready, 1);
   endtask

   initial begin
      t_reset_auto();
      t_vendor_b_plain();
      t_a_quad_first();
      t_a_quad_retry();
      t_a_quad_exhaust();
      t_b_quad();
      t_start_busy();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule